// File: doc/BRIEF.md
# Machine Interrupt Pending and Arbitration

This block is the interrupt-detection slice of a 64-bit RISC-V machine-mode CSR unit. It shows four level-sensitive request lines (software, timer, external and a debug-agent request) as the machine interrupt-pending word. It keeps the machine interrupt-enable word, and decides from both words whether the hart must trap now and with which cause value.

The debug-agent request lets an outside debugger force the hart into a trap. It sits at cause 14. It is always enabled and ignores the global machine interrupt-enable bit from the status register. The three standard sources need both their own enable bit and the global bit. The take strobe and the cause value are combinational, and a trap-entry busy input holds the strobe low. Trap entry, delegation and lower privilege levels belong to other blocks.

Top module: `mint_ctrl`

## Requirements
- R1: After synchronous reset the writable enable bits (3, 7, 11) are zero, so reading the enable word (`csr_rd_sel` = 0) returns 0x4000.
- R2: A write with `csr_wr_en` = 1 and `csr_wr_sel` = 0 loads bits 3, 7 and 11 of `csr_wr_data` into the enable word at the next clock edge. Bit 14 always reads 1 whatever is written. All other bits read 0.
- R3: Reading the pending word (`csr_rd_sel` = 1) returns, in the same cycle, `sw_req` at bit 3, `timer_req` at bit 7, `ext_req` at bit 11 and `dbg_req` at bit 14, with all other bits 0.
- R4: A write with `csr_wr_sel` = 1 has no effect: the pending word still follows the inputs, and the enable word is unchanged.
- R5: Software, timer and external interrupts raise `take_irq` only when their request, their enable bit and `mstatus_mie` are all 1.
- R6: A debug request raises `take_irq` with cause 14 even when `mstatus_mie` is 0 and whatever was written to enable bit 14.
- R7: When several sources are eligible, the winner is chosen in this order: debug (14), then external (11), then software (3), then timer (7).
- R8: While `take_irq` is 1, `irq_cause` has bit 63 set and the winning cause code in bits 3:0, with all other bits 0. While `take_irq` is 0, `irq_cause` is 0.
- R9: While `trap_busy` is 1, `take_irq` is 0.
- R10: When a request input drops, its pending bit and any interrupt taken from it clear in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Machine software interrupt request, level |
| timer_req | input | 1 | Machine timer interrupt request, level |
| ext_req | input | 1 | Machine external interrupt request, level |
| dbg_req | input | 1 | Debug-agent interrupt request, level |
| mstatus_mie | input | 1 | Global machine interrupt-enable bit |
| trap_busy | input | 1 | Trap entry in progress; holds off the strobe |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_sel | input | 1 | Write target: 0 enable word, 1 pending word |
| csr_wr_data | input | 64 | CSR write data |
| csr_rd_sel | input | 1 | Read source: 0 enable word, 1 pending word |
| csr_rd_data | output | 64 | CSR read data |
| take_irq | output | 1 | Take-interrupt strobe |
| irq_cause | output | 64 | Cause value for the taken interrupt |

## Verification
The bench aims at the debug line with the global enable clear and with enable bit 14 written as 0. A design that gates debug like the other sources would then never trap. It drives all four requests at once and then removes them one by one, which shows a wrong priority order as the wrong cause code. It writes all ones to the pending word and compares the read-back with the inputs, so a design that latches those writes shows up as stuck pending bits. It also drops requests between edges: a design that registers the pending word would keep the strobe high for one more cycle.

// File: rtl/mint_pkg.sv
package mint_pkg;

    localparam int XLEN    = 64;
    localparam int CODE_W  = 4;
    localparam int NSRC    = 4;

    localparam int BIT_SW  = 3;
    localparam int BIT_TMR = 7;
    localparam int BIT_EXT = 11;
    localparam int BIT_DBG = 14;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_SW  = CODE_W'(BIT_SW),
        CAUSE_TMR = CODE_W'(BIT_TMR),
        CAUSE_EXT = CODE_W'(BIT_EXT),
        CAUSE_DBG = CODE_W'(BIT_DBG)
    } cause_e;

    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } csr_sel_e;

    // Field order is priority order: the most significant field wins.
    typedef struct packed {
        logic dbg;
        logic ext;
        logic sw;
        logic tmr;
    } src_vec_t;

    localparam logic [XLEN-1:0] ENABLE_WRITABLE =
        (XLEN'(1) << BIT_SW) | (XLEN'(1) << BIT_TMR) | (XLEN'(1) << BIT_EXT);
    localparam logic [XLEN-1:0] ENABLE_FORCED = XLEN'(1) << BIT_DBG;

    function automatic logic [XLEN-1:0] place_sources(src_vec_t v);
        logic [XLEN-1:0] w;
        w          = '0;
        w[BIT_SW]  = v.sw;
        w[BIT_TMR] = v.tmr;
        w[BIT_EXT] = v.ext;
        w[BIT_DBG] = v.dbg;
        return w;
    endfunction

    function automatic src_vec_t pick_sources(logic [XLEN-1:0] w);
        src_vec_t v;
        v.sw  = w[BIT_SW];
        v.tmr = w[BIT_TMR];
        v.ext = w[BIT_EXT];
        v.dbg = w[BIT_DBG];
        return v;
    endfunction

    // Index follows the flattened src_vec_t: 0 = lowest priority.
    function automatic cause_e code_of_slot(int idx);
        case (idx)
            0:       return CAUSE_TMR;
            1:       return CAUSE_SW;
            2:       return CAUSE_EXT;
            default: return CAUSE_DBG;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] cause_word(logic hit, cause_e code);
        logic [XLEN-1:0] w;
        w = '0;
        if (hit) begin
            w[XLEN-1]     = 1'b1;
            w[CODE_W-1:0] = code;
        end
        return w;
    endfunction

endpackage

// File: rtl/mint_enable_reg.sv
module mint_enable_reg
    import mint_pkg::*;
#(
    parameter logic [XLEN-1:0] WRITABLE = ENABLE_WRITABLE,
    parameter logic [XLEN-1:0] FORCED   = ENABLE_FORCED
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] enable_word
);

    logic [XLEN-1:0] stored_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
        end else if (wr_en) begin
            stored_q <= wr_data & WRITABLE;
        end
    end

    assign enable_word = stored_q | FORCED;

    // R2: a write lands on the writable bits one edge later, forced bits stay set
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> enable_word == (($past(wr_data) & WRITABLE) | FORCED));

    // R2: without a write the enable word holds
    a_r2_holds_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(enable_word));

endmodule

// File: rtl/mint_pending.sv
module mint_pending
    import mint_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  src_vec_t        requests,
    input  logic [XLEN-1:0] enable_word,
    input  logic            global_en,
    output logic [XLEN-1:0] pending_word,
    output src_vec_t        eligible
);

    src_vec_t enables;

    assign pending_word = place_sources(requests);
    assign enables      = pick_sources(enable_word);

    always_comb begin
        eligible.dbg = requests.dbg;
        eligible.ext = requests.ext & enables.ext & global_en;
        eligible.sw  = requests.sw  & enables.sw  & global_en;
        eligible.tmr = requests.tmr & enables.tmr & global_en;
    end

    // R5: a standard source is eligible only with the global enable set
    a_r5_needs_global: assert property (@(posedge clk) disable iff (rst)
        (eligible.ext || eligible.sw || eligible.tmr) |-> global_en);

    // R10: nothing is eligible without a live request
    a_r10_level_only: assert property (@(posedge clk) disable iff (rst)
        (eligible != '0) |-> (requests != '0));

endmodule

// File: rtl/mint_arbiter.sv
module mint_arbiter
    import mint_pkg::*;
(
    input  src_vec_t eligible,
    output logic     hit,
    output cause_e   code
);

    logic [NSRC-1:0] flat;
    cause_e          slot_code [NSRC];

    assign flat = eligible;

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        assign slot_code[g] = code_of_slot(g);
    end

    always_comb begin
        hit  = 1'b0;
        code = CAUSE_TMR;
        for (int i = 0; i < NSRC; i++) begin
            if (flat[i]) begin
                hit  = 1'b1;
                code = slot_code[i];
            end
        end
    end

endmodule

// File: rtl/mint_ctrl.sv
module mint_ctrl
    import mint_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_req,
    input  logic            timer_req,
    input  logic            ext_req,
    input  logic            dbg_req,
    input  logic            mstatus_mie,
    input  logic            trap_busy,
    input  logic            csr_wr_en,
    input  logic            csr_wr_sel,
    input  logic [63:0]     csr_wr_data,
    input  logic            csr_rd_sel,
    output logic [63:0]     csr_rd_data,
    output logic            take_irq,
    output logic [63:0]     irq_cause
);

    src_vec_t        requests;
    src_vec_t        eligible;
    logic [XLEN-1:0] enable_word;
    logic [XLEN-1:0] pending_word;
    logic            enable_wr;
    logic            arb_hit;
    cause_e          arb_code;

    assign requests.dbg = dbg_req;
    assign requests.ext = ext_req;
    assign requests.sw  = sw_req;
    assign requests.tmr = timer_req;

    // Writes aimed at the pending word are dropped: it follows the pins.
    assign enable_wr = csr_wr_en && (csr_wr_sel == SEL_ENABLE);

    mint_enable_reg i_enable (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (enable_wr),
        .wr_data     (csr_wr_data),
        .enable_word (enable_word)
    );

    mint_pending i_pending (
        .clk          (clk),
        .rst          (rst),
        .requests     (requests),
        .enable_word  (enable_word),
        .global_en    (mstatus_mie),
        .pending_word (pending_word),
        .eligible     (eligible)
    );

    mint_arbiter i_arbiter (
        .eligible (eligible),
        .hit      (arb_hit),
        .code     (arb_code)
    );

    assign csr_rd_data = (csr_rd_sel == SEL_PENDING) ? pending_word : enable_word;
    assign take_irq    = arb_hit && !trap_busy;
    assign irq_cause   = cause_word(take_irq, arb_code);

    // R9: busy holds the strobe off
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        trap_busy |-> !take_irq);

    // R6: a debug request wins regardless of the enables
    a_r6_debug_forced: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !trap_busy) |-> (take_irq && irq_cause[3:0] == 4'd14));

    // R8: interrupt flag accompanies the strobe, cause is zero otherwise
    a_r8_cause_flag: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> irq_cause[63]);
    a_r8_cause_idle: assert property (@(posedge clk) disable iff (rst)
        !take_irq |-> irq_cause == '0);

    // R7: external outranks software and timer
    a_r7_ext_over_low: assert property (@(posedge clk) disable iff (rst)
        (take_irq && !dbg_req && ext_req && enable_word[BIT_EXT]) |->
            irq_cause[3:0] == 4'd11);

    // R4: a write to the pending word leaves the enable word alone
    a_r4_pending_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && csr_wr_sel) |=> $stable(enable_word));

endmodule

// File: tb/test_mint_ctrl.sv
module test_mint_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_req = 0, timer_req = 0, ext_req = 0, dbg_req = 0;
    logic        mstatus_mie = 0, trap_busy = 0;
    logic        csr_wr_en = 0, csr_wr_sel = 0, csr_rd_sel = 0;
    logic [63:0] csr_wr_data = '0;
    logic [63:0] csr_rd_data;
    logic        take_irq;
    logic [63:0] irq_cause;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_en;   // bench model of the enable word

    always #10 clk = ~clk;   // 50 MHz

    mint_ctrl i_mint_ctrl (
        .clk(clk), .rst(rst),
        .sw_req(sw_req), .timer_req(timer_req), .ext_req(ext_req), .dbg_req(dbg_req),
        .mstatus_mie(mstatus_mie), .trap_busy(trap_busy),
        .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel), .csr_wr_data(csr_wr_data),
        .csr_rd_sel(csr_rd_sel), .csr_rd_data(csr_rd_data),
        .take_irq(take_irq), .irq_cause(irq_cause)
    );

    function automatic logic [63:0] exp_pending();
        logic [63:0] w = '0;
        w[3] = sw_req; w[7] = timer_req; w[11] = ext_req; w[14] = dbg_req;
        return w;
    endfunction

    function automatic logic [63:0] exp_cause();
        logic [3:0] c;
        logic hit = 1'b1;
        if (dbg_req)                                 c = 4'd14;
        else if (ext_req && m_en[11] && mstatus_mie) c = 4'd11;
        else if (sw_req && m_en[3] && mstatus_mie)   c = 4'd3;
        else if (timer_req && m_en[7] && mstatus_mie) c = 4'd7;
        else begin c = 4'd0; hit = 1'b0; end
        if (!hit || trap_busy) return 64'd0;
        return {1'b1, 59'd0, c};
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare strobe, cause and both read views against the model.
    task automatic check_all(string tag);
        logic [63:0] ec = exp_cause();
        check64({tag, " take"}, {63'd0, take_irq}, {63'd0, ec[63]});
        check64({tag, " cause"}, irq_cause, ec);
        csr_rd_sel = 1'b1; #1;
        check64({tag, " pending R3"}, csr_rd_data, exp_pending());
        csr_rd_sel = 1'b0; #1;
        check64({tag, " enable"}, csr_rd_data, m_en);
    endtask

    task automatic set_req(logic s, logic t, logic e, logic d);
        sw_req = s; timer_req = t; ext_req = e; dbg_req = d;
    endtask

    // Drive a CSR write through one clock edge and update the model.
    task automatic csr_write(logic sel, logic [63:0] data);
        @(negedge clk);
        csr_wr_en = 1'b1; csr_wr_sel = sel; csr_wr_data = data;
        @(posedge clk); #1;
        if (sel == 1'b0) m_en = (data & 64'h0888) | 64'h4000;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); #3;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_en = 64'h4000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        settle();
        // R1: reset state
        check64("R1 enable after reset", csr_rd_data, 64'h4000);
        check_all("R1 idle");

        // R2: write all ones, only 3/7/11 stick, 14 forced
        csr_write(1'b0, '1);
        settle();
        check64("R2 enable all ones", csr_rd_data, 64'h4888);
        // R2: writing zero keeps bit 14
        csr_write(1'b0, 64'd0);
        settle();
        check64("R2 bit14 forced", csr_rd_data, 64'h4000);

        // R6: debug with everything disabled
        set_req(0, 0, 0, 1); mstatus_mie = 1'b0;
        settle();
        check_all("R6 debug global off");
        check64("R6 cause", irq_cause, 64'h8000_0000_0000_000E);

        // R5: standard sources blocked by the enable bits
        set_req(1, 1, 1, 0); mstatus_mie = 1'b1;
        settle();
        check64("R5 masked by enable", {63'd0, take_irq}, 64'd0);
        csr_write(1'b0, 64'h0888);
        mstatus_mie = 1'b0;
        settle();
        check64("R5 masked by global", {63'd0, take_irq}, 64'd0);
        mstatus_mie = 1'b1;

        // R7: priority ladder
        set_req(1, 1, 1, 1); settle(); check64("R7 all -> 14", irq_cause, 64'h8000_0000_0000_000E);
        set_req(1, 1, 1, 0); settle(); check64("R7 no dbg -> 11", irq_cause, 64'h8000_0000_0000_000B);
        set_req(1, 1, 0, 0); settle(); check64("R7 sw+tmr -> 3", irq_cause, 64'h8000_0000_0000_0003);
        set_req(0, 1, 0, 0); settle(); check64("R7 tmr -> 7", irq_cause, 64'h8000_0000_0000_0007);

        // R9: busy suppresses even debug
        set_req(0, 0, 0, 1); trap_busy = 1'b1;
        settle();
        check64("R9 busy take", {63'd0, take_irq}, 64'd0);
        check64("R8 busy cause zero", irq_cause, 64'd0);
        trap_busy = 1'b0;

        // R4: write ones to pending word; nothing changes
        set_req(0, 0, 0, 0);
        csr_write(1'b1, '1);
        settle();
        check_all("R4 pending write dropped");

        // R10: drop a request between edges
        set_req(0, 0, 1, 0);
        settle();
        check64("R10 ext taken", irq_cause, 64'h8000_0000_0000_000B);
        #2 ext_req = 1'b0; #1;
        check64("R10 drop take", {63'd0, take_irq}, 64'd0);
        csr_rd_sel = 1'b1; #1;
        check64("R10 pending cleared", csr_rd_data, 64'd0);
        csr_rd_sel = 1'b0;

        // Random mix for R5 to R8
        void'($urandom(32'h1A2B));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r = $urandom();
            if (r[31:29] == 3'd0) csr_write(r[28], {$urandom(), $urandom()});
            @(negedge clk);
            set_req(r[0], r[1], r[2], r[3] & r[4]);
            mstatus_mie = r[5];
            trap_busy   = (r[8:6] == 3'd0);
            #3;
            check_all("R5 R6 R7 R8 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule